// File: doc/BRIEF.md
# Mesh Sweep Sequencer with Vector Output Writes

This block runs one short microprogram for every point of a two-dimensional vertex grid. Software first loads the microprogram and the general registers through a word-addressed register port. It then sets the base address and the last column and row indices, and sets the start bit. The block walks the rows from top to bottom and, inside each row, the columns from left to right. At every grid point it seeds two general registers with the coordinates and runs the program from its first word. The run ends when the program issues a vector-output instruction. That instruction pushes two 32-bit words, byte-swapped into big-endian order, to memory over a valid/ready write port.

Arithmetic is done outside this block. The block decodes each instruction, hands the opcode and two operand values to an external arithmetic unit with a start pulse, and waits for that unit's done strobe. It then writes the result back into the register file. A run that never produces a vector output is cut off after a fixed instruction budget, and the sweep moves on to the next point. When the last point is finished, the block stores the number of points visited and gives a single-cycle interrupt.

The memory slot for a point does not depend on the programmed grid width. Each point owns 8 bytes, and every row is 128 points wide.

Top module: `mesh_sweep_seq`

## Requirements
- R1: A synchronous active-low reset clears the base, index, page, vertex-count and last-output registers, all 128 general registers and the program counter. After reset, irq, dma_valid and alu_start are 0.
- R2: Writing a word with bit 0 set to offset 0 starts a sweep. Bit 0 of offset 0 reads as 1 while the sweep runs and as 0 once it has ended.
- R3: The sweep visits rows y = 0 up to the row-last value and, inside each row, columns x = 0 up to the column-last value, both inclusive. Before each run, general register 0 holds x, general register 1 holds y, and execution starts at program word 0.
- R4: A vector output writes operand A to base + 8*(128*y + x) and operand B to that address + 4, in that order. Each data word is the register value byte-swapped: register bits 7:0 appear on dma_data bits 31:24.
- R5: dma_valid stays high with dma_addr and dma_data unchanged until dma_ready is seen. The sequencer does not advance past a word until that word is accepted.
- R6: After each vector output, the last-output register (offset 6) holds the address of the second word written.
- R7: A run that has executed 2048 instructions without a vector output is abandoned, and the sweep continues at the next point. A vector output found as the 2048th instruction is still performed.
- R8: Instruction fields are operand A register in bits 24:18, operand B register in bits 17:11, opcode in bits 10:7 and destination register in bits 6:0. Opcode 7 is the vector output and opcode 0 does nothing. Any other opcode gives a one-cycle alu_start with alu_op, alu_a and alu_b, and waits for alu_done. alu_result is then written to the destination register, unless the destination is register 0, in which case nothing is written.
- R9: Word offsets 0x100 to 0x17F read and write general registers 0 to 127 directly.
- R10: Word offsets 0x200 to 0x3FF reach program word page*512 + (offset - 0x200), where page is the register at offset 4.
- R11: When the sweep ends, offset 5 reads (column-last + 1) * (row-last + 1) and irq is high for exactly one cycle.
- R12: All register-port writes are ignored while a sweep runs. Reads still return data.
- R13: Register offsets are: 0 control, 1 base address, 2 column-last, 3 row-last, 4 code page, 5 vertex count, 6 last output address. Read data appears on reg_rdata one cycle after reg_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 10 | Word offset of a register-port access |
| reg_we | input | 1 | Write strobe for the register port |
| reg_wdata | input | 32 | Register-port write data |
| reg_rdata | output | 32 | Read data, registered, for the previous cycle's reg_addr |
| irq | output | 1 | One-cycle pulse when a sweep has ended |
| dma_valid | output | 1 | A memory write word is offered |
| dma_ready | input | 1 | Memory accepts the offered word |
| dma_addr | output | 32 | Byte address of the offered word |
| dma_data | output | 32 | Big-endian data of the offered word |
| alu_start | output | 1 | One-cycle request to the arithmetic unit |
| alu_op | output | 4 | Opcode of the request |
| alu_a | output | 32 | Operand A value |
| alu_b | output | 32 | Operand B value |
| alu_flags | output | 32 | Current content of general register 2 |
| alu_done | input | 1 | Arithmetic result is valid this cycle |
| alu_result | input | 32 | Arithmetic result |

## Verification
The embedded assertions check the following on every cycle: the output handshake holds its word until it is accepted, the interrupt is a single cycle, the instruction counter never passes its budget, and start pulses are single cycles. They also check that the coordinate load never collides with another register-file write, and that a write arriving during a sweep leaves the configuration untouched. The bench scenarios are the only evidence for the end-to-end properties. These are the row-major visiting order with the right coordinates in registers 0 and 1, the slot addresses and byte swapping under random back-pressure, destination-register write-back including the discarded register 0 case, the paged program window, and the vertex count. The same applies to the exact budget boundary: a vector output at the 2048th instruction is kept, and a program with none is cut off.

// File: rtl/mesh_seq_pkg.sv
// Package: shared offsets, instruction layout, sequencer states and helpers.
// Assumes a 10-bit word offset on the register port and 128 general registers.
package mesh_seq_pkg;

    localparam int WORD_W = 32;
    localparam int REG_AW = 10;

    localparam logic [REG_AW-1:0] OFS_CTL   = 10'h000;
    localparam logic [REG_AW-1:0] OFS_BASE  = 10'h001;
    localparam logic [REG_AW-1:0] OFS_HLAST = 10'h002;
    localparam logic [REG_AW-1:0] OFS_VLAST = 10'h003;
    localparam logic [REG_AW-1:0] OFS_PAGE  = 10'h004;
    localparam logic [REG_AW-1:0] OFS_VCNT  = 10'h005;
    localparam logic [REG_AW-1:0] OFS_LAST  = 10'h006;

    localparam logic [3:0] OPC_NOP  = 4'd0;
    localparam logic [3:0] OPC_VOUT = 4'd7;

    typedef struct packed {
        logic [6:0] spare;
        logic [6:0] ra;
        logic [6:0] rb;
        logic [3:0] op;
        logic [6:0] rd;
    } insn_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_EXEC,
        ST_ALU,
        ST_DMA_A,
        ST_DMA_B,
        ST_NEXT
    } seq_state_t;

    // Reverse byte order of a word for big-endian memory.
    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

endpackage

// File: rtl/mesh_gpr_file.sv
// General register file: three instruction read ports, one host read port,
// one write port, and a dedicated port that loads the grid coordinates into
// registers 0 and 1 in the same cycle.
// Assumes the coordinate load and the write port are never active together.
module mesh_gpr_file #(
    parameter int NREG = 128,
    parameter int W    = 32,
    parameter int FLAG_IDX = 2,
    localparam int IW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic          xy_load,
    input  logic [W-1:0]  x_val,
    input  logic [W-1:0]  y_val,
    input  logic [IW-1:0] rd_a_idx,
    output logic [W-1:0]  rd_a,
    input  logic [IW-1:0] rd_b_idx,
    output logic [W-1:0]  rd_b,
    input  logic [IW-1:0] rd_h_idx,
    output logic [W-1:0]  rd_h,
    output logic [W-1:0]  flags
);

    logic [W-1:0] regs_q [NREG];

    // Register storage: reset clear, coordinate seeding, single write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (xy_load) begin
            regs_q[0] <= x_val;
            regs_q[1] <= y_val;
        end else if (wr_en) begin
            regs_q[wr_idx] <= wr_data;
        end
    end

    // Combinational read ports.
    always_comb begin
        rd_a  = regs_q[rd_a_idx];
        rd_b  = regs_q[rd_b_idx];
        rd_h  = regs_q[rd_h_idx];
        flags = regs_q[FLAG_IDX];
    end

    assert_one_writer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        xy_load |-> !wr_en);

endmodule

// File: rtl/mesh_code_store.sv
// Microprogram store: one write port, a fetch read port and a host read port.
// Not reset; software loads it before the first sweep.
module mesh_code_store #(
    parameter int DEPTH = 2048,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] fetch_addr,
    output logic [W-1:0]  fetch_data,
    input  logic [AW-1:0] host_addr,
    output logic [W-1:0]  host_data
);

    logic [W-1:0] mem_q [DEPTH];

    // Word write from the host window.
    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    // Combinational fetch and host read.
    always_comb begin
        fetch_data = mem_q[fetch_addr];
        host_data  = mem_q[host_addr];
    end

endmodule

// File: rtl/mesh_slot_addr.sv
// Slot address generator: each grid point owns an 8-byte slot, and rows are
// a fixed 2**IDX_W points apart whatever the programmed width.
module mesh_slot_addr #(
    parameter int ADDR_W    = 32,
    parameter int IDX_W     = 7,
    parameter int SLOT_LOG2 = 3
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  x,
    input  logic [IDX_W-1:0]  y,
    output logic [ADDR_W-1:0] addr_a,
    output logic [ADDR_W-1:0] addr_b
);

    localparam int OFF_W = 2 * IDX_W + SLOT_LOG2;

    logic [OFF_W-1:0] offset;

    // Row-major slot offset plus second-word address.
    always_comb begin
        offset = {y, x, {SLOT_LOG2{1'b0}}};
        addr_a = base + ADDR_W'(offset);
        addr_b = addr_a + ADDR_W'(4);
    end

endmodule

// File: rtl/mesh_sweep_seq.sv
// Mesh sweep sequencer: a register port for configuration and program
// loading, a row-major grid walk, a per-point instruction engine with an
// external arithmetic handshake, two-word vector output over valid/ready,
// a runaway guard and an end-of-sweep interrupt.
// Assumes the external arithmetic unit answers every alu_start with one
// alu_done and never raises alu_done unrequested.
module mesh_sweep_seq
    import mesh_seq_pkg::*;
#(
    parameter int NGPR       = 128,
    parameter int CODE_DEPTH = 2048,
    parameter int PAGE_WORDS = 512,
    parameter int RUN_LIMIT  = 2048,
    parameter int ROW_PITCH  = 128,
    parameter int ADDR_W     = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic                reg_we,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                irq,
    output logic                dma_valid,
    input  logic                dma_ready,
    output logic [ADDR_W-1:0]   dma_addr,
    output logic [WORD_W-1:0]   dma_data,
    output logic                alu_start,
    output logic [3:0]          alu_op,
    output logic [WORD_W-1:0]   alu_a,
    output logic [WORD_W-1:0]   alu_b,
    output logic [WORD_W-1:0]   alu_flags,
    input  logic                alu_done,
    input  logic [WORD_W-1:0]   alu_result
);

    localparam int GPR_IW  = $clog2(NGPR);
    localparam int CODE_AW = $clog2(CODE_DEPTH);
    localparam int PAGE_AW = $clog2(PAGE_WORDS);
    localparam int PG_W    = CODE_AW - PAGE_AW;
    localparam int IDX_W   = $clog2(ROW_PITCH);
    localparam int CNT_W   = $clog2(RUN_LIMIT + 1);
    localparam int VCNT_W  = 2 * IDX_W + 1;

    seq_state_t          state_q;
    logic [ADDR_W-1:0]   base_q, last_q;
    logic [IDX_W-1:0]    hlast_q, vlast_q, x_q, y_q;
    logic [PG_W-1:0]     page_q;
    logic [VCNT_W-1:0]   vcnt_q;
    logic [CODE_AW-1:0]  pc_q;
    logic [CNT_W-1:0]    icnt_q;
    logic [6:0]          rd_q;
    logic [3:0]          op_q;
    logic [WORD_W-1:0]   opa_q, opb_q;
    logic                alu_start_q, irq_q;

    logic                busy, host_wr, start_req, gpr_win, code_win;
    logic                gpr_we, xy_load, code_we;
    logic [GPR_IW-1:0]   gpr_widx;
    logic [WORD_W-1:0]   gpr_wdata, rd_a, rd_b, rd_h, flags;
    logic [WORD_W-1:0]   fetch_data, code_hdata;
    logic [CODE_AW-1:0]  host_code_addr;
    logic [ADDR_W-1:0]   slot_a, slot_b;
    logic [VCNT_W-1:0]   cols, rows;
    insn_t               ins;

    // Host access decode; every write is dropped while a sweep runs.
    always_comb begin
        busy           = (state_q != ST_IDLE);
        host_wr        = reg_we && !busy;
        start_req      = host_wr && (reg_addr == OFS_CTL) && reg_wdata[0];
        gpr_win        = (reg_addr[REG_AW-1:GPR_IW] == 3'b010);
        code_win       = reg_addr[REG_AW-1];
        host_code_addr = {page_q, reg_addr[PAGE_AW-1:0]};
        code_we        = host_wr && code_win;
        ins            = insn_t'(fetch_data);
        xy_load        = (state_q == ST_SETUP);
        cols           = VCNT_W'(hlast_q) + VCNT_W'(1);
        rows           = VCNT_W'(vlast_q) + VCNT_W'(1);
    end

    // Register-file write source: host window when idle, result when busy.
    always_comb begin
        if (busy) begin
            gpr_we    = (state_q == ST_ALU) && alu_done && (rd_q != 7'd0);
            gpr_widx  = GPR_IW'(rd_q);
            gpr_wdata = alu_result;
        end else begin
            gpr_we    = host_wr && gpr_win;
            gpr_widx  = reg_addr[GPR_IW-1:0];
            gpr_wdata = reg_wdata;
        end
    end

    mesh_gpr_file #(.NREG(NGPR), .W(WORD_W), .FLAG_IDX(2)) u_gpr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (gpr_we),
        .wr_idx   (gpr_widx),
        .wr_data  (gpr_wdata),
        .xy_load  (xy_load),
        .x_val    (WORD_W'(x_q)),
        .y_val    (WORD_W'(y_q)),
        .rd_a_idx (GPR_IW'(ins.ra)),
        .rd_a     (rd_a),
        .rd_b_idx (GPR_IW'(ins.rb)),
        .rd_b     (rd_b),
        .rd_h_idx (reg_addr[GPR_IW-1:0]),
        .rd_h     (rd_h),
        .flags    (flags)
    );

    mesh_code_store #(.DEPTH(CODE_DEPTH), .W(WORD_W)) u_code (
        .clk        (clk),
        .wr_en      (code_we),
        .wr_addr    (host_code_addr),
        .wr_data    (reg_wdata),
        .fetch_addr (pc_q),
        .fetch_data (fetch_data),
        .host_addr  (host_code_addr),
        .host_data  (code_hdata)
    );

    mesh_slot_addr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SLOT_LOG2(3)) u_slot (
        .base   (base_q),
        .x      (x_q),
        .y      (y_q),
        .addr_a (slot_a),
        .addr_b (slot_b)
    );

    // Configuration registers written by software while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            hlast_q <= '0;
            vlast_q <= '0;
            page_q  <= '0;
        end else if (host_wr) begin
            case (reg_addr)
                OFS_BASE:  base_q  <= reg_wdata[ADDR_W-1:0];
                OFS_HLAST: hlast_q <= reg_wdata[IDX_W-1:0];
                OFS_VLAST: vlast_q <= reg_wdata[IDX_W-1:0];
                OFS_PAGE:  page_q  <= reg_wdata[PG_W-1:0];
                default:   ;
            endcase
        end
    end

    // Sweep walk, instruction engine, output writes and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            x_q         <= '0;
            y_q         <= '0;
            pc_q        <= '0;
            icnt_q      <= '0;
            rd_q        <= '0;
            op_q        <= OPC_NOP;
            opa_q       <= '0;
            opb_q       <= '0;
            alu_start_q <= 1'b0;
            irq_q       <= 1'b0;
            vcnt_q      <= '0;
            last_q      <= '0;
        end else begin
            alu_start_q <= 1'b0;
            irq_q       <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_req) begin
                        x_q     <= '0;
                        y_q     <= '0;
                        state_q <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    pc_q    <= '0;
                    icnt_q  <= '0;
                    state_q <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (icnt_q == CNT_W'(RUN_LIMIT)) begin
                        state_q <= ST_NEXT;
                    end else begin
                        icnt_q <= icnt_q + CNT_W'(1);
                        opa_q  <= rd_a;
                        opb_q  <= rd_b;
                        if (ins.op == OPC_VOUT) begin
                            state_q <= ST_DMA_A;
                        end else if (ins.op == OPC_NOP) begin
                            pc_q <= pc_q + CODE_AW'(1);
                        end else begin
                            op_q        <= ins.op;
                            rd_q        <= ins.rd;
                            alu_start_q <= 1'b1;
                            pc_q        <= pc_q + CODE_AW'(1);
                            state_q     <= ST_ALU;
                        end
                    end
                end
                ST_ALU: begin
                    if (alu_done) state_q <= ST_EXEC;
                end
                ST_DMA_A: begin
                    if (dma_ready) state_q <= ST_DMA_B;
                end
                ST_DMA_B: begin
                    if (dma_ready) begin
                        last_q  <= slot_b;
                        state_q <= ST_NEXT;
                    end
                end
                ST_NEXT: begin
                    if (x_q != hlast_q) begin
                        x_q     <= x_q + IDX_W'(1);
                        state_q <= ST_SETUP;
                    end else if (y_q != vlast_q) begin
                        x_q     <= '0;
                        y_q     <= y_q + IDX_W'(1);
                        state_q <= ST_SETUP;
                    end else begin
                        vcnt_q  <= cols * rows;
                        irq_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Registered read-back for the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (gpr_win) begin
            reg_rdata <= rd_h;
        end else if (code_win) begin
            reg_rdata <= code_hdata;
        end else begin
            case (reg_addr)
                OFS_CTL:   reg_rdata <= WORD_W'(busy);
                OFS_BASE:  reg_rdata <= WORD_W'(base_q);
                OFS_HLAST: reg_rdata <= WORD_W'(hlast_q);
                OFS_VLAST: reg_rdata <= WORD_W'(vlast_q);
                OFS_PAGE:  reg_rdata <= WORD_W'(page_q);
                OFS_VCNT:  reg_rdata <= WORD_W'(vcnt_q);
                OFS_LAST:  reg_rdata <= WORD_W'(last_q);
                default:   reg_rdata <= '0;
            endcase
        end
    end

    // Output drive.
    always_comb begin
        irq       = irq_q;
        dma_valid = (state_q == ST_DMA_A) || (state_q == ST_DMA_B);
        dma_addr  = (state_q == ST_DMA_B) ? slot_b : slot_a;
        dma_data  = swap_bytes((state_q == ST_DMA_B) ? opb_q : opa_q);
        alu_start = alu_start_q;
        alu_op    = op_q;
        alu_a     = opa_q;
        alu_b     = opb_q;
        alu_flags = flags;
    end

    assert_dma_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid && !dma_ready |=> dma_valid && $stable(dma_addr) && $stable(dma_data));

    assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_guard_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        icnt_q <= CNT_W'(RUN_LIMIT));

    assert_alu_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        alu_start |=> !alu_start);

    assert_busy_ignore_R12: assert property (@(posedge clk) disable iff (!rst_n)
        busy && reg_we |=> $stable(base_q) && $stable(hlast_q) && $stable(vlast_q) && $stable(page_q));

    assert_dma_in_sweep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid |-> !irq && !alu_start);

endmodule

// File: tb/mesh_sweep_seq_test.sv
// Bench: sweeps several grid shapes with three microprograms, random output
// back-pressure and a behavioural arithmetic unit; expected values are
// computed from the requirements.
module mesh_sweep_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, dma_valid, dma_ready, alu_start, alu_done;
    logic [31:0] dma_addr, dma_data, alu_a, alu_b, alu_flags, alu_result;
    logic [3:0]  alu_op;

    int n_chk = 0, n_fail = 0, cyc = 0, irq_cnt = 0;
    int prog = 1, cur_h = 0, ex = 0, ey = 0, ph = 0, n_words = 0;
    logic [31:0] mbase = '0;
    bit stall_en = 0, finished = 0;
    logic [15:0] lfsr = 16'hACE1;
    int alu_cnt = 0;
    logic [3:0]  al_op = '0;
    logic [31:0] al_a = '0, al_b = '0;

    mesh_sweep_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_addr(dma_addr),
        .dma_data(dma_data), .alu_start(alu_start), .alu_op(alu_op),
        .alu_a(alu_a), .alu_b(alu_b), .alu_flags(alu_flags),
        .alu_done(alu_done), .alu_result(alu_result)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] bsw(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] mk(input int ra, input int rb, input int op, input int rd);
        return {7'd0, 7'(ra), 7'(rb), 4'(op), 7'(rd)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Back-pressure source, updated after each edge.
    always @(posedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        dma_ready <= stall_en ? lfsr[0] : 1'b1;
    end

    // Behavioural arithmetic unit: opcode 12 copies A, others add.
    always @(posedge clk) begin
        if (!rst_n) alu_cnt <= 0;
        else if (alu_start) begin
            alu_cnt <= 3; al_op <= alu_op; al_a <= alu_a; al_b <= alu_b;
        end else if (alu_cnt != 0) alu_cnt <= alu_cnt - 1;
    end
    assign alu_done   = (alu_cnt == 1);
    assign alu_result = (al_op == 4'd12) ? al_a : al_a + al_b;

    // Monitor: cycle count, interrupts, accepted output words, watchdog.
    always @(negedge clk) begin
        cyc++;
        if (rst_n && irq) irq_cnt++;
        if (rst_n && alu_start)
            check(alu_op == 4'd12 || alu_op == 4'd1, "R8 alu_op", 32'(alu_op), 32'd12);
        if (rst_n && dma_valid && dma_ready) begin
            logic [31:0] ea, ev;
            ea = mbase + 32'(8 * (128 * ey + ex) + 4 * ph);
            if (prog == 1) ev = (ph != 0) ? 32'(ey) : 32'(ex);
            else           ev = (ph != 0) ? 32'(ex) : 32'(ex + ey);
            check(dma_addr == ea, "R4 slot address", dma_addr, ea);
            check(dma_data == bsw(ev), "R3 R8 output data", dma_data, bsw(ev));
            n_words++;
            if (ph != 0) begin
                if (ex == cur_h) begin ex = 0; ey++; end
                else ex++;
            end
            ph ^= 1;
        end
        if (cyc > 190000 && !finished) begin
            finished = 1;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        reg_addr = 10'(a); reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 10'(a);
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic code_wr(input int idx, input logic [31:0] v);
        wr(4, 32'(idx / 512));
        wr(32'h200 + idx % 512, v);
    endtask

    task automatic sweep(input int h, input int v, input logic [31:0] b, input int p,
                         input bit stall, input int exp_words, output int len);
        logic [31:0] r;
        int i0, t0;
        prog = p; stall_en = stall; cur_h = h; mbase = b;
        ex = 0; ey = 0; ph = 0; n_words = 0;
        wr(2, 32'(h)); wr(3, 32'(v)); wr(1, b);
        i0 = irq_cnt; t0 = cyc;
        wr(0, 32'd1);
        rd(0, r);
        check(r == 32'd1, "R2 busy reads 1", r, 32'd1);
        wr(1, 32'hDEAD0000);
        wr(2, 32'd5);
        while (irq_cnt == i0 && cyc - t0 < 60000) @(negedge clk);
        len = cyc - t0;
        repeat (3) @(negedge clk);
        check(irq_cnt == i0 + 1, "R11 single irq", 32'(irq_cnt - i0), 32'd1);
        rd(0, r);
        check(r == 32'd0, "R2 idle reads 0", r, 32'd0);
        rd(1, r);
        check(r == b, "R12 base kept", r, b);
        rd(2, r);
        check(r == 32'(h), "R12 column-last kept", r, 32'(h));
        rd(5, r);
        check(r == 32'((h + 1) * (v + 1)), "R11 vertex count", r, 32'((h + 1) * (v + 1)));
        check(n_words == exp_words, "R3 R7 word count", 32'(n_words), 32'(exp_words));
        if (exp_words > 0) begin
            rd(6, r);
            check(r == b + 32'(8 * (128 * v + h) + 4), "R6 last address", r,
                  b + 32'(8 * (128 * v + h) + 4));
        end
    endtask

    initial begin
        logic [31:0] r;
        int len;
        dma_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        wr(32'h109, 32'hCAFE0009);
        wr(1, 32'h12340000);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(irq == 1'b0 && dma_valid == 1'b0 && alu_start == 1'b0, "R1 outputs idle",
              {29'd0, irq, dma_valid, alu_start}, 32'd0);
        rd(0, r);     check(r == 0, "R1 control", r, 0);
        rd(1, r);     check(r == 0, "R1 base", r, 0);
        rd(32'h109, r); check(r == 0, "R1 general register", r, 0);
        rd(5, r);     check(r == 0, "R1 vertex count", r, 0);
        rd(6, r);     check(r == 0, "R1 last address", r, 0);

        // R9: general register window
        wr(32'h109, 32'hCAFE0009);
        rd(32'h109, r); check(r == 32'hCAFE0009, "R9 register window", r, 32'hCAFE0009);
        rd(32'h10A, r); check(r == 0, "R9 neighbour untouched", r, 0);

        // Clear the whole program store page by page.
        for (int p = 0; p < 4; p++) begin
            wr(4, 32'(p));
            for (int i = 0; i < 512; i++) wr(32'h200 + i, 32'd0);
        end

        // R10: paged program window
        wr(4, 32'd2); wr(32'h205, 32'h0BADF00D);
        wr(4, 32'd0); rd(32'h205, r);
        check(r == 0, "R10 other page", r, 0);
        wr(4, 32'd2); rd(32'h205, r);
        check(r == 32'h0BADF00D, "R10 selected page", r, 32'h0BADF00D);
        wr(32'h205, 32'd0);
        rd(4, r); check(r == 32'd2, "R13 page register", r, 32'd2);

        // Program 1: output x then y.
        code_wr(0, mk(0, 1, 7, 0));
        sweep(0, 0, 32'h0000_1000, 1, 0, 2, len);
        sweep(2, 1, 32'h0001_0004, 1, 1, 12, len);
        sweep(127, 1, 32'h8000_0000, 1, 0, 512, len);
        sweep(3, 3, 32'h0002_0000, 1, 1, 32, len);

        // Program 2: discarded write to r0, copy, add, output.
        code_wr(0, mk(1, 0, 12, 0));
        code_wr(1, mk(0, 0, 12, 5));
        code_wr(2, mk(5, 1, 1, 6));
        code_wr(3, mk(6, 0, 7, 0));
        sweep(3, 2, 32'h0004_0000, 2, 1, 24, len);

        // R7 boundary: output as the 2048th instruction is kept.
        for (int i = 0; i < 4; i++) code_wr(i, 32'd0);
        code_wr(2047, mk(0, 1, 7, 0));
        sweep(1, 0, 32'h0005_0000, 1, 0, 4, len);

        // R7: no output at all, each run is cut off.
        code_wr(2047, 32'd0);
        sweep(1, 0, 32'h0006_0000, 1, 0, 0, len);
        check(len >= 2 * 2048 && len < 2 * 2048 + 40, "R7 guard duration", 32'(len), 32'd4100);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule